// File: doc/BRIEF.md
# Real-Mode Physical Address Generator

This block turns a segment value and an offset into a physical byte address, the way a processor running in real mode does. The segment is moved up by a fixed number of bit places and the offset is added to it. The block samples a request when its valid strobe is high. One clock later it presents the address on registered outputs, together with two flags. One flag marks accesses that land in the band just above the base address space. The other reports a fault when an access falls outside a programmable window.

A configuration port loads three things: the address-line mode, the window enable and the window bounds. In wrap mode the carry out of the base address width is dropped, so addresses fold back to the bottom of memory. In wide mode that carry drives one extra address line, which makes the high band reachable. Many segment:offset pairs resolve to the same physical address, and the block treats all of them alike. With the default parameters the segment and offset are 16 bits each, the shift is 4, and the output is 21 bits wide.

Top module: `agen_realmode`

## Requirements
- R1: One clock edge after a strobe, `phys_addr` holds (seg_i << SHIFT) + off_i. Here AW = SEG_W + SHIFT, and `phys_addr` is AW+1 bits wide.
- R2: In wrap mode (mode bit 0), bit AW of `phys_addr` is 0 and the address equals the sum modulo 2^AW.
- R3: In wide mode (mode bit 1), the carry out of bit AW-1 appears in bit AW. The address equals the full sum.
- R4: `hma_hit` is 1 exactly when a strobe is taken in wide mode and the sum lies between 2^AW and ((2^SEG_W-1) << SHIFT) + 2^OFF_W - 1, both ends included. With the default parameters this range is 0x100000 to 0x10FFEF.
- R5: When the window is enabled, a strobe whose final address is below the base or above the limit gives `limit_fault`=1 and `out_valid`=0. A strobe inside the window, both bounds included, gives `out_valid`=1 and `limit_fault`=0.
- R6: When the window is disabled, `limit_fault` stays 0 and every strobe gives `out_valid`=1.
- R7: Different segment:offset pairs with the same sum produce identical outputs.
- R8: A cycle with no strobe gives `out_valid`, `hma_hit` and `limit_fault` all 0 on the next cycle, and `phys_addr` keeps its previous value.
- R9: Settings loaded with `cfg_we` apply to strobes in later cycles. A strobe taken in the same cycle as the load uses the previous settings.
- R10: Reset clears all outputs. It also selects wrap mode, disables the window and clears both bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads mode, window enable and bounds |
| cfg_wide | input | 1 | Mode to load: 0 = wrap, 1 = wide |
| cfg_win_en | input | 1 | Window check enable to load |
| cfg_win_base | input | AW+1 (21) | Lowest permitted address |
| cfg_win_limit | input | AW+1 (21) | Highest permitted address |
| in_valid | input | 1 | Request strobe |
| seg_i | input | SEG_W (16) | Segment value |
| off_i | input | OFF_W (16) | Offset value |
| out_valid | output | 1 | Access completed without fault |
| phys_addr | output | AW+1 (21) | Registered physical address |
| hma_hit | output | 1 | Access landed in the band above 2^AW |
| limit_fault | output | 1 | Access fell outside the enabled window |

## Verification
The bench builds the block with SEG_W=6, OFF_W=8 and SHIFT=4. That gives a 10-bit base address, a carry line at bit 10 and a high band from 0x400 to 0x4EF. These small widths make it possible to sweep all 16384 segment:offset pairs in wrap mode, in wide mode, and in wide mode with a window that straddles the high band. Every aliasing pair, every carry and both window bounds are therefore covered. Directed cases then cover the same-cycle load ordering, idle cycles and the reset state.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic {
    MODE_WRAP = 1'b0,
    MODE_WIDE = 1'b1
  } mode_e;
endpackage

// File: rtl/agen_cfg.sv
module agen_cfg #(
  parameter int unsigned AW = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_wide,
  input  logic            cfg_win_en,
  input  logic [AW:0]     base_i,
  input  logic [AW:0]     limit_i,
  output agen_pkg::mode_e mode_o,
  output logic            win_en_o,
  output logic [AW:0]     base_o,
  output logic [AW:0]     limit_o
);
  agen_pkg::mode_e mode_q, mode_d;
  logic            en_q, en_d;
  logic [AW:0]     base_q, base_d, limit_q, limit_d;

  always_comb begin
    mode_d  = mode_q;
    en_d    = en_q;
    base_d  = base_q;
    limit_d = limit_q;
    if (cfg_we) begin
      mode_d  = cfg_wide ? agen_pkg::MODE_WIDE : agen_pkg::MODE_WRAP;
      en_d    = cfg_win_en;
      base_d  = base_i;
      limit_d = limit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= agen_pkg::MODE_WRAP;
      en_q    <= 1'b0;
      base_q  <= '0;
      limit_q <= '0;
    end else begin
      mode_q  <= mode_d;
      en_q    <= en_d;
      base_q  <= base_d;
      limit_q <= limit_d;
    end
  end

  assign mode_o   = mode_q;
  assign win_en_o = en_q;
  assign base_o   = base_q;
  assign limit_o  = limit_q;
endmodule

// File: rtl/agen_sum.sv
module agen_sum #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 4,
  localparam int unsigned AW   = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  input  agen_pkg::mode_e  mode_i,
  output logic [AW:0]      addr_o
);
  logic [AW:0] seg_ext, off_ext, raw;
  logic        carry_keep;

  assign seg_ext = {1'b0, seg_i, {SHIFT{1'b0}}};

  generate
    if (OFF_W > AW) begin : g_bad_width
      initial $error("offset wider than shifted segment");
      assign off_ext = off_i[AW:0];
    end else if (OFF_W == AW + 1) begin : g_full_width
      assign off_ext = off_i;
    end else begin : g_pad
      assign off_ext = {{(AW + 1 - OFF_W){1'b0}}, off_i};
    end
  endgenerate

  assign raw        = seg_ext + off_ext;
  assign carry_keep = (mode_i == agen_pkg::MODE_WIDE);
  assign addr_o     = {raw[AW] & carry_keep, raw[AW-1:0]};
endmodule

// File: rtl/agen_win.sv
module agen_win #(
  parameter int unsigned AW = 20
) (
  input  logic [AW:0] addr_i,
  input  logic        en_i,
  input  logic [AW:0] base_i,
  input  logic [AW:0] limit_i,
  output logic        fault_o
);
  logic below, above;
  assign below   = addr_i < base_i;
  assign above   = addr_i > limit_i;
  assign fault_o = en_i & (below | above);
endmodule

// File: rtl/agen_realmode.sv
module agen_realmode #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 4,
  localparam int unsigned AW   = SEG_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_wide,
  input  logic             cfg_win_en,
  input  logic [AW:0]      cfg_win_base,
  input  logic [AW:0]      cfg_win_limit,
  input  logic             in_valid,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             out_valid,
  output logic [AW:0]      phys_addr,
  output logic             hma_hit,
  output logic             limit_fault
);
  localparam logic [AW:0] HMA_LO = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] HMA_HI = {1'b0, {SEG_W{1'b1}}, {SHIFT{1'b0}}}
                                 + {{(AW + 1 - OFF_W){1'b0}}, {OFF_W{1'b1}}};

  agen_pkg::mode_e mode;
  logic            win_en;
  logic [AW:0]     win_base, win_limit;
  logic [AW:0]     addr;
  logic            fault;

  agen_cfg #(.AW(AW)) i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wide(cfg_wide),
    .cfg_win_en(cfg_win_en), .base_i(cfg_win_base), .limit_i(cfg_win_limit),
    .mode_o(mode), .win_en_o(win_en), .base_o(win_base), .limit_o(win_limit)
  );

  agen_sum #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) i_sum (
    .seg_i(seg_i), .off_i(off_i), .mode_i(mode), .addr_o(addr)
  );

  agen_win #(.AW(AW)) i_win (
    .addr_i(addr), .en_i(win_en), .base_i(win_base), .limit_i(win_limit),
    .fault_o(fault)
  );

  logic        vld_q, vld_d, hma_q, hma_d, flt_q, flt_d;
  logic [AW:0] addr_q, addr_d;
  logic        in_band;

  assign in_band = (addr >= HMA_LO) && (addr <= HMA_HI);

  always_comb begin
    vld_d  = in_valid & ~fault;
    flt_d  = in_valid & fault;
    hma_d  = in_valid & (mode == agen_pkg::MODE_WIDE) & in_band;
    addr_d = addr_q;
    if (in_valid) addr_d = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hma_q  <= 1'b0;
      flt_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q  <= vld_d;
      hma_q  <= hma_d;
      flt_q  <= flt_d;
      addr_q <= addr_d;
    end
  end

  assign out_valid   = vld_q;
  assign phys_addr   = addr_q;
  assign hma_hit     = hma_q;
  assign limit_fault = flt_q;

  p_wrap_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == agen_pkg::MODE_WRAP) |=> !phys_addr[AW]);

  p_band_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == agen_pkg::MODE_WRAP) |=> !hma_hit);

  p_fault_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && limit_fault));

  p_inside_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && addr >= win_base && addr <= win_limit) |=> out_valid);

  p_no_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !win_en) |=> (out_valid && !limit_fault));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !hma_hit && !limit_fault && $stable(phys_addr)));
endmodule

// File: tb/test_agen_realmode.sv
module test_agen_realmode;
  localparam int SEG_W = 6;
  localparam int OFF_W = 8;
  localparam int SHIFT = 4;
  localparam int AW    = SEG_W + SHIFT;
  localparam int BAND_LO = 1 << AW;
  localparam int BAND_HI = (((1 << SEG_W) - 1) << SHIFT) + (1 << OFF_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_wide, cfg_win_en;
  logic [AW:0] cfg_win_base, cfg_win_limit;
  logic in_valid;
  logic [SEG_W-1:0] seg_i;
  logic [OFF_W-1:0] off_i;
  logic out_valid, hma_hit, limit_fault;
  logic [AW:0] phys_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit tb_wide = 0, tb_en = 0;
  int tb_base = 0, tb_limit = 0;

  always #10 clk = ~clk;

  agen_realmode #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) i_agen_realmode (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wide(cfg_wide),
    .cfg_win_en(cfg_win_en), .cfg_win_base(cfg_win_base), .cfg_win_limit(cfg_win_limit),
    .in_valid(in_valid), .seg_i(seg_i), .off_i(off_i), .out_valid(out_valid),
    .phys_addr(phys_addr), .hma_hit(hma_hit), .limit_fault(limit_fault)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input bit w, input bit e, input int b, input int l);
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b1; cfg_wide = w; cfg_win_en = e;
    cfg_win_base = (AW+1)'(b); cfg_win_limit = (AW+1)'(l);
    @(negedge clk);
    cfg_we = 1'b0;
    tb_wide = w; tb_en = e; tb_base = b; tb_limit = l;
  endtask

  task automatic req(input int s, input int o);
    int sum, a;
    bit h, f;
    @(negedge clk);
    in_valid = 1'b1; seg_i = SEG_W'(s); off_i = OFF_W'(o);
    @(posedge clk); #5;
    sum = (s << SHIFT) + o;
    a = tb_wide ? sum : sum % (1 << AW);
    h = tb_wide && sum >= BAND_LO && sum <= BAND_HI;
    f = tb_en && (a < tb_base || a > tb_limit);
    chk(int'(phys_addr) == a, tb_wide ? "R3 wide address" : "R2 wrap address", int'(phys_addr), a);
    chk(hma_hit == h, "R4 band flag", int'(hma_hit), int'(h));
    chk(out_valid == !f && limit_fault == f, tb_en ? "R5 window" : "R6 no window",
        int'({out_valid, limit_fault}), int'({!f, f}));
  endtask

  task automatic sweep();
    for (int s = 0; s < (1 << SEG_W); s++)
      for (int o = 0; o < (1 << OFF_W); o++)
        req(s, o);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int first;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wide = 1'b0; cfg_win_en = 1'b0;
    cfg_win_base = '0; cfg_win_limit = '0; in_valid = 1'b0; seg_i = '0; off_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #5;
    // R10 reset state and default wrap mode
    chk(!out_valid && !hma_hit && !limit_fault && phys_addr == '0, "R10 reset outputs",
        int'({out_valid, hma_hit, limit_fault, phys_addr}), 0);
    req(6'h3F, 8'hFF);
    chk(int'(phys_addr) == 'hEF, "R10 wrap after reset", int'(phys_addr), 'hEF);
    // R1 basic sum
    req(6'h21, 8'h37);
    chk(int'(phys_addr) == 'h247, "R1 shifted sum", int'(phys_addr), 'h247);
    // R7 aliasing
    req(6'h12, 8'h34);
    first = int'(phys_addr);
    req(6'h13, 8'h24);
    chk(int'(phys_addr) == first && first == 'h154, "R7 alias", int'(phys_addr), first);
    // full sweeps
    sweep();
    cfg(1'b1, 1'b0, 0, 0);
    sweep();
    cfg(1'b1, 1'b1, 'h100, 'h44F);
    sweep();
    // R8 idle cycle after a band hit
    cfg(1'b1, 1'b0, 0, 0);
    req(6'h3F, 8'h20);
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #5;
    chk(!out_valid && !hma_hit && !limit_fault, "R8 idle flags",
        int'({out_valid, hma_hit, limit_fault}), 0);
    chk(int'(phys_addr) == 'h410, "R8 address hold", int'(phys_addr), 'h410);
    // R9 load and strobe in the same cycle
    cfg(1'b0, 1'b0, 0, 0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wide = 1'b1; cfg_win_en = 1'b0;
    in_valid = 1'b1; seg_i = 6'h3F; off_i = 8'hFF;
    @(posedge clk); #5;
    chk(int'(phys_addr) == 'hEF, "R9 old mode used", int'(phys_addr), 'hEF);
    @(negedge clk); cfg_we = 1'b0;
    @(posedge clk); #5;
    chk(int'(phys_addr) == 'h4EF && hma_hit, "R9 new mode used", int'(phys_addr), 'h4EF);
    @(negedge clk); in_valid = 1'b0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule